// File: doc/BRIEF.md
# UART sleep and wake controller

This block decides when a group of UART channels may stop their oscillator and when they must restart it. Each channel reports its local state: sleep request, pending interrupt, FIFO emptiness, receive pin level, infrared mode, baud divisor and the four modem-status change bits. The block combines these channel reports into one device-wide decision. The oscillator and the register file are outside this block.

When every channel is quiet for a programmable number of reference clocks, the block closes the clock gate and reports sleep. Any single channel can end the sleep. Causes are a dropped sleep request, a raised interrupt, a write to a transmit holding register, or an edge on a receive or modem pin. On every wake the block raises an indicator interrupt that no mask can hold back. Software clears it by acknowledging it. Once every cause has gone away, the block goes back to sleep by itself.

The block runs from an always-on reference clock. Pin levels are brought in through two-stage synchronizers before they are used. The reset is asynchronous, active low, and released synchronously inside the block.

Top module: `uart_slp_ctrl`

## Requirements
- R1: While reset is applied, and until the first sleep, `asleep_o` is 0, `clk_gate_en_o` is 1 and `wake_irq_o` is 0.
- R2: The block goes to sleep when the device-wide entry condition has held at `settle_cycles_i`+1 consecutive rising clock edges. `asleep_o` rises after the last of those edges. A single edge at which the condition fails restarts the count. With `settle_cycles_i` = 0, one edge is enough.
- R3: A channel permits sleep only when all of these hold: `sleep_en_i` is 1, `irq_pend_i` is 0, `tx_empty_i` and `rx_empty_i` are both 1, its `DIV_W`-bit field of `divisor_i` is nonzero, and its 4-bit field of `msr_delta_i` is zero. If any one of these fails, the device stays awake.
- R4: The receive pin counts as idle when it is high and `ir_mode_i` = 0, or when it is low and `ir_mode_i` = 1. The pin is seen two edges after it changes.
- R5: Sleep requires the channel conditions of R3 and R4 on every channel. Channel k uses bit k of the 1-bit vectors and bits [k*W +: W] of the packed fields.
- R6: While asleep, any of these wakes the device: `sleep_en_i` low, `irq_pend_i` high, or a `thr_wr_i` pulse on any channel. `asleep_o` falls after the next rising edge.
- R7: While asleep, a change of level on any channel's receive pin or modem pin wakes the device. `asleep_o` falls after the third rising edge that follows the change.
- R8: While asleep with no wake cause present, `asleep_o` stays 1.
- R9: After a wake, the block re-enters sleep without further action once the entry condition again holds for the count of R2.
- R10: Every exit from sleep sets `wake_irq_o`, regardless of any interrupt enable. It stays set until an edge at which `wake_ack_i` is 1. A wake and an acknowledge at the same edge leave it set.
- R11: `clk_gate_en_o` is always the inverse of `asleep_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| settle_cycles_i | input | CNT_W | Extra qualifying edges before sleep |
| sleep_en_i | input | NCH | Per-channel sleep request |
| irq_pend_i | input | NCH | Per-channel interrupt pending |
| tx_empty_i | input | NCH | Per-channel transmit FIFO empty |
| rx_empty_i | input | NCH | Per-channel receive FIFO empty |
| rx_pin_i | input | NCH | Per-channel receive pin, asynchronous |
| ir_mode_i | input | NCH | Per-channel infrared mode (inverts idle level) |
| divisor_i | input | NCH*DIV_W | Per-channel baud divisor |
| msr_delta_i | input | NCH*4 | Per-channel modem status change bits 3..0 |
| modem_pin_i | input | NCH*MDM_W | Per-channel modem input pins, asynchronous |
| thr_wr_i | input | NCH | Per-channel transmit holding write strobe |
| wake_ack_i | input | 1 | Clears the wake indicator |
| clk_gate_en_o | output | 1 | Oscillator enable, 1 = running |
| asleep_o | output | 1 | Sleep status |
| wake_irq_o | output | 1 | Wake indicator interrupt |

## Verification
A stale qualification count shows at the ports as a sleep that begins one or more edges early or late. The bench therefore samples `asleep_o` on both sides of the expected entry edge, and also after a one-cycle break in the condition. A wrong synchronizer depth or a broken edge detector moves the pin-driven wake away from its third edge. A lost wake cause leaves `asleep_o` high where it must fall, and this is visible one edge after the cause. A wrong indicator state shows in `wake_irq_o` right after a wake or an acknowledge. A missed re-entry shows as a device that stays awake after the count of R2.

// File: rtl/uart_slp_pkg.sv
package uart_slp_pkg;
  localparam int MSR_W = 4;

  typedef enum logic [1:0] {
    SLP_RUN   = 2'd0,
    SLP_QUAL  = 2'd1,
    SLP_SLEEP = 2'd2
  } slp_state_e;
endpackage

// File: rtl/uart_slp_sync2.sv
module uart_slp_sync2 #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/uart_slp_chan_mon.sv
module uart_slp_chan_mon
  import uart_slp_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int MDM_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_en_i,
  input  logic             irq_pend_i,
  input  logic             tx_empty_i,
  input  logic             rx_empty_i,
  input  logic             rx_pin_i,
  input  logic             ir_mode_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic [MSR_W-1:0] msr_delta_i,
  input  logic [MDM_W-1:0] modem_pin_i,
  input  logic             thr_wr_i,
  output logic             entry_ok_o,
  output logic             wake_o
);
  localparam int PIN_W = MDM_W + 1;

  logic [PIN_W-1:0] pins_raw, pins_s, prev_q, prev_d;
  logic             rx_s, rx_idle, pin_edge;

  assign pins_raw = {modem_pin_i, rx_pin_i};

  uart_slp_sync2 #(.W(PIN_W)) u_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_s)
  );

  // previous synchronized level, for edge sensing
  always_comb prev_d = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end

  always_comb begin
    rx_s     = pins_s[0];
    rx_idle  = ir_mode_i ? ~rx_s : rx_s;
    pin_edge = |(pins_s ^ prev_q);
  end

  always_comb begin
    entry_ok_o = sleep_en_i & ~irq_pend_i & tx_empty_i & rx_empty_i &
                 rx_idle & (|divisor_i) & (msr_delta_i == '0);
    wake_o     = ~sleep_en_i | irq_pend_i | thr_wr_i | pin_edge;
  end
endmodule

// File: rtl/uart_slp_fsm.sv
module uart_slp_fsm
  import uart_slp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             all_ok_i,
  input  logic             any_wake_i,
  input  logic [CNT_W-1:0] settle_i,
  input  logic             wake_ack_i,
  output logic             asleep_o,
  output logic             wake_irq_o
);
  slp_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    irq_d = irq_q;
    if (wake_ack_i) irq_d = 1'b0;
    unique case (st_q)
      SLP_RUN: begin
        if (all_ok_i) begin
          if (settle_i == '0) begin
            st_d = SLP_SLEEP;
          end else begin
            st_d  = SLP_QUAL;
            cnt_d = CNT_W'(1);
          end
        end
      end
      SLP_QUAL: begin
        if (!all_ok_i) begin
          st_d  = SLP_RUN;
          cnt_d = '0;
        end else if (cnt_q >= settle_i) begin
          st_d  = SLP_SLEEP;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      SLP_SLEEP: begin
        if (any_wake_i) begin
          st_d  = SLP_RUN;
          irq_d = 1'b1;
        end
      end
      default: st_d = SLP_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SLP_RUN;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign asleep_o   = (st_q == SLP_SLEEP);
  assign wake_irq_o = irq_q;

  // R8
  hold_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o && !any_wake_i |=> asleep_o);

  // R6
  wake_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o && any_wake_i |=> !asleep_o && wake_irq_o);

  // R10
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o && !wake_ack_i |=> wake_irq_o);

  // R10
  irq_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_irq_o) |-> $fell(asleep_o));
endmodule

// File: rtl/uart_slp_ctrl.sv
module uart_slp_ctrl
  import uart_slp_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int DIV_W = 16,
  parameter int MDM_W = 4,
  parameter int CNT_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [CNT_W-1:0]       settle_cycles_i,
  input  logic [NCH-1:0]         sleep_en_i,
  input  logic [NCH-1:0]         irq_pend_i,
  input  logic [NCH-1:0]         tx_empty_i,
  input  logic [NCH-1:0]         rx_empty_i,
  input  logic [NCH-1:0]         rx_pin_i,
  input  logic [NCH-1:0]         ir_mode_i,
  input  logic [NCH*DIV_W-1:0]   divisor_i,
  input  logic [NCH*MSR_W-1:0]   msr_delta_i,
  input  logic [NCH*MDM_W-1:0]   modem_pin_i,
  input  logic [NCH-1:0]         thr_wr_i,
  input  logic                   wake_ack_i,
  output logic                   clk_gate_en_o,
  output logic                   asleep_o,
  output logic                   wake_irq_o
);
  logic [1:0]     rst_pipe_q;
  logic           rst_sn;
  logic [NCH-1:0] chan_ok, chan_wake;
  logic           all_ok, any_wake;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    uart_slp_chan_mon #(.DIV_W(DIV_W), .MDM_W(MDM_W)) u_mon (
      .clk_i       (clk_i),
      .rst_ni      (rst_sn),
      .sleep_en_i  (sleep_en_i[k]),
      .irq_pend_i  (irq_pend_i[k]),
      .tx_empty_i  (tx_empty_i[k]),
      .rx_empty_i  (rx_empty_i[k]),
      .rx_pin_i    (rx_pin_i[k]),
      .ir_mode_i   (ir_mode_i[k]),
      .divisor_i   (divisor_i[k*DIV_W +: DIV_W]),
      .msr_delta_i (msr_delta_i[k*MSR_W +: MSR_W]),
      .modem_pin_i (modem_pin_i[k*MDM_W +: MDM_W]),
      .thr_wr_i    (thr_wr_i[k]),
      .entry_ok_o  (chan_ok[k]),
      .wake_o      (chan_wake[k])
    );
  end

  assign all_ok   = &chan_ok;
  assign any_wake = |chan_wake;

  uart_slp_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_sn),
    .all_ok_i   (all_ok),
    .any_wake_i (any_wake),
    .settle_i   (settle_cycles_i),
    .wake_ack_i (wake_ack_i),
    .asleep_o   (asleep_o),
    .wake_irq_o (wake_irq_o)
  );

  assign clk_gate_en_o = ~asleep_o;

  // R5
  entry_all_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    $rose(asleep_o) |-> $past(&chan_ok));

  // R6
  thr_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    asleep_o && (|thr_wr_i) |=> !asleep_o);

  // R11
  gate_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    clk_gate_en_o != asleep_o);
endmodule

// File: tb/uart_slp_ctrl_tb.sv
module uart_slp_ctrl_tb;
  localparam int NCH = 2, DIV_W = 16, MDM_W = 4, CNT_W = 8;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [CNT_W-1:0]     settle;
  logic [NCH-1:0]       sleep_en, irq_pend, tx_empty, rx_empty, rx_pin, ir_mode, thr_wr;
  logic [NCH*DIV_W-1:0] divisor;
  logic [NCH*4-1:0]     msr_delta;
  logic [NCH*MDM_W-1:0] modem_pin;
  logic                 wake_ack;
  logic                 gate_en, asleep, wake_irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    string tag;
    logic  a;
    logic  w;
  } exp_t;
  exp_t exp_q[$];
  event chk_ev;

  always #10 clk = ~clk;

  uart_slp_ctrl #(.NCH(NCH), .DIV_W(DIV_W), .MDM_W(MDM_W), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .settle_cycles_i(settle),
    .sleep_en_i(sleep_en), .irq_pend_i(irq_pend), .tx_empty_i(tx_empty),
    .rx_empty_i(rx_empty), .rx_pin_i(rx_pin), .ir_mode_i(ir_mode),
    .divisor_i(divisor), .msr_delta_i(msr_delta), .modem_pin_i(modem_pin),
    .thr_wr_i(thr_wr), .wake_ack_i(wake_ack),
    .clk_gate_en_o(gate_en), .asleep_o(asleep), .wake_irq_o(wake_irq));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(input string tag, input logic a, input logic w);
    exp_t e;
    e.tag = tag; e.a = a; e.w = w;
    exp_q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (asleep !== e.a || gate_en !== ~e.a || wake_irq !== e.w) begin
          errors++;
          $display("FAIL %s actual asleep=%b gate=%b irq=%b expected asleep=%b gate=%b irq=%b",
                   e.tag, asleep, gate_en, wake_irq, e.a, ~e.a, e.w);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; settle = 8'd3;
    sleep_en = 2'b11; irq_pend = 2'b00; tx_empty = 2'b10; rx_empty = 2'b11;
    rx_pin = 2'b11; ir_mode = 2'b00; thr_wr = 2'b00; wake_ack = 1'b0;
    divisor = {16'd4, 16'd4}; msr_delta = '0; modem_pin = '0;
    step(3);
    expect_st("R1 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    step(10);
    expect_st("R3 tx fifo not empty blocks", 1'b0, 1'b0);
    // R2 entry timing with settle 3: four qualifying edges
    tx_empty = 2'b11;
    step(3);
    expect_st("R2 not yet after three edges", 1'b0, 1'b0);
    step(1);
    expect_st("R2 asleep after fourth edge, R11 gate low", 1'b1, 1'b0);
    step(20);
    expect_st("R8 stays asleep", 1'b1, 1'b0);
    // R6 holding register write wakes
    thr_wr = 2'b01;
    step(1);
    thr_wr = 2'b00;
    expect_st("R6 thr write wake, R10 irq set", 1'b0, 1'b1);
    step(3);
    expect_st("R9 still qualifying", 1'b0, 1'b1);
    step(1);
    expect_st("R9 re-entered sleep", 1'b1, 1'b1);
    wake_ack = 1'b1;
    step(1);
    wake_ack = 1'b0;
    expect_st("R10 ack clears indicator", 1'b1, 1'b0);
    step(5);
    expect_st("R8 asleep after ack", 1'b1, 1'b0);
    // R6 interrupt pending wakes and blocks
    irq_pend = 2'b10;
    step(1);
    expect_st("R6 irq wake", 1'b0, 1'b1);
    step(5);
    expect_st("R3 irq pending blocks", 1'b0, 1'b1);
    wake_ack = 1'b1;
    step(1);
    wake_ack = 1'b0;
    expect_st("R10 ack while awake", 1'b0, 1'b0);
    // R2 glitch restarts count
    irq_pend = 2'b00;
    step(2);
    irq_pend = 2'b10;
    step(1);
    irq_pend = 2'b00;
    step(3);
    expect_st("R2 count restarted by glitch", 1'b0, 1'b0);
    step(1);
    expect_st("R2 asleep after clean run", 1'b1, 1'b0);
    // R7 receive pin activity
    rx_pin = 2'b10;
    step(2);
    expect_st("R7 not woken before third edge", 1'b1, 1'b0);
    step(1);
    expect_st("R7 rx edge wake", 1'b0, 1'b1);
    step(10);
    expect_st("R4 low rx not idle in normal mode", 1'b0, 1'b1);
    wake_ack = 1'b1;
    step(1);
    wake_ack = 1'b0;
    expect_st("R10 ack", 1'b0, 1'b0);
    // R4 infrared mode: low is idle
    ir_mode = 2'b01;
    step(3);
    expect_st("R4 ir qualifying", 1'b0, 1'b0);
    step(1);
    expect_st("R4 ir low idle allows sleep", 1'b1, 1'b0);
    // R6 sleep disable wakes, R5 one channel keeps device awake
    sleep_en = 2'b10;
    step(1);
    expect_st("R6 sleep disable wake", 1'b0, 1'b1);
    step(10);
    expect_st("R5 one channel disabled", 1'b0, 1'b1);
    sleep_en = 2'b11;
    wake_ack = 1'b1;
    step(1);
    wake_ack = 1'b0;
    expect_st("R10 ack after re-enable", 1'b0, 1'b0);
    step(3);
    expect_st("R9 re-entry after enable", 1'b1, 1'b0);
    // R7 modem pin activity on channel 1 pin 2
    modem_pin = 8'h40;
    step(2);
    expect_st("R7 modem not before third edge", 1'b1, 1'b0);
    step(1);
    expect_st("R7 modem edge wake", 1'b0, 1'b1);
    step(4);
    expect_st("R9 re-entry after modem wake", 1'b1, 1'b1);
    wake_ack = 1'b1;
    step(1);
    wake_ack = 1'b0;
    // R3 zero divisor on channel 1
    divisor = {16'd0, 16'd4};
    thr_wr = 2'b10;
    step(1);
    thr_wr = 2'b00;
    expect_st("R6 thr wake channel 1", 1'b0, 1'b1);
    step(10);
    expect_st("R3 zero divisor blocks", 1'b0, 1'b1);
    // R3 modem change bits on channel 0
    divisor = {16'd4, 16'd4};
    msr_delta = 8'h01;
    wake_ack = 1'b1;
    step(1);
    wake_ack = 1'b0;
    step(9);
    expect_st("R3 modem change bits block", 1'b0, 1'b0);
    msr_delta = '0;
    step(3);
    expect_st("R3 qualifying after clear", 1'b0, 1'b0);
    step(1);
    expect_st("R3 asleep after clear", 1'b1, 1'b0);
    // R2 zero settle count
    settle = 8'd0;
    thr_wr = 2'b01;
    step(1);
    thr_wr = 2'b00;
    expect_st("R6 wake before zero settle", 1'b0, 1'b1);
    step(1);
    expect_st("R2 zero settle one edge", 1'b1, 1'b1);
    // R10 wake and ack at one edge: set wins
    irq_pend = 2'b01;
    wake_ack = 1'b1;
    step(1);
    wake_ack = 1'b0;
    irq_pend = 2'b00;
    expect_st("R10 set beats ack", 1'b0, 1'b1);
    step(2);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule